// File: doc/BRIEF.md
# Internal Clock Source Selector

This block picks the system clock for a device that runs from its own internal oscillators. It runs on an 8 MHz fast reference clock. It also takes a one-cycle tick that marks each period of a slow reference of about 31 kHz, already brought into the fast clock domain. The system clock leaves the block as a clock-enable pulse train `sys_ce` on the fast clock. A 3-bit select field chooses one of three paths: the slow reference, the fast reference divided by a power of two from 2 to 64, or the fast reference undivided. A requested change waits until the current output period ends, so every output period has its full length.

The block also computes the run requests for both oscillators. The slow oscillator is needed when the internal block drives the system clock, or when any of four features is enabled: the power-up timer, the fail-safe clock monitor, the watchdog and the two-speed start-up. The fast oscillator is needed whenever a divided or undivided fast path is requested or active. The block also drives the function selects for the two oscillator pins. Depending on the pin mode, each pin serves the oscillator, becomes a general-purpose I/O bit, or carries the system clock divided by four.

The path control is a three-state machine that holds the active path: PATH_SLOW, PATH_DIV and PATH_DIRECT. It has two transitions. T_STAY applies in any cycle without an output pulse: the active selection and state are kept. T_APPLY applies in a cycle with an output pulse: the requested selection is loaded, its state is entered, and the postscaler counter restarts from zero if the selection changed.

Top module: `intclk_selector`

## Requirements
- R1: While reset is held and after it is released, the active selection is 111 (fast undivided), and the divide-by-four clock starts low. With pin mode 01 and the fast path active, `osc2_out` reads 0,0,1,1,0,0 in the first six cycles after reset.
- R2: With active selection 111, `sys_ce` is high in every fast clock cycle.
- R3: Active selections 001, 010, 011, 100, 101 and 110 give one single-cycle `sys_ce` pulse every 64, 32, 16, 8, 4 and 2 fast cycles respectively.
- R4: With active selection 000, `sys_ce` is high exactly in the cycles where `slow_tick` is high.
- R5: A new `freq_sel` value becomes active only in the cycle after a `sys_ce` pulse. The first period after a change has exactly the new length. While the slow path is active and `slow_tick` stays low, no change is applied.
- R6: `fast_osc_en` is high when `freq_sel` is not 000 or when the active path is not the slow path. It is low when both the requested and the active selections are 000.
- R7: `slow_osc_en` is high when any of `int_src_sel`, `en_pwrup_tmr`, `en_fail_mon`, `en_wdog`, `en_two_speed` is high, and low when none is.
- R8: The pin mode decodes as follows. 00 and 11: both pins serve the oscillator (no GPIO, no clock output). 01: pin 1 is GPIO and pin 2 drives the clock output. 10: both pins are GPIO.
- R9: The divide-by-four clock inverts after every second `sys_ce` pulse, which gives a 50% duty square wave. It appears on `osc2_out` only in pin mode 01; in every other mode `osc2_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | 8 MHz fast reference, the block's clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_sel | input | 3 | Requested system frequency select |
| slow_tick | input | 1 | One-cycle tick per slow reference period |
| int_src_sel | input | 1 | Internal block chosen as system clock source |
| en_pwrup_tmr | input | 1 | Power-up timer enabled |
| en_fail_mon | input | 1 | Fail-safe clock monitor enabled |
| en_wdog | input | 1 | Watchdog enabled |
| en_two_speed | input | 1 | Two-speed start-up enabled |
| pin_mode | input | 2 | Oscillator pin function mode |
| sys_ce | output | 1 | System clock enable pulse |
| fast_osc_en | output | 1 | Fast oscillator run request |
| slow_osc_en | output | 1 | Slow oscillator run request |
| osc1_gpio | output | 1 | Oscillator pin 1 used as GPIO |
| osc2_gpio | output | 1 | Oscillator pin 2 used as GPIO |
| osc2_clk_en | output | 1 | Oscillator pin 2 drives the clock output |
| osc2_out | output | 1 | Value driven on oscillator pin 2 |

## Verification
Assertions check these rules in every cycle:
- the active selection holds between pulses;
- the undivided path pulses in every cycle and the slow path follows its tick;
- the postscaler counter restarts at zero after a change;
- the clock output changes only after an enable;
- the pin functions exclude each other;
- the oscillator requests follow the watchdog and the active path.

Only the bench's scenarios can show the following:
- the exact period of each divide ratio;
- the length of the first period after a change made in mid-period;
- the phase of the clock output after reset;
- the held selection while the slow tick is absent.

// File: rtl/intclk_pkg.sv
package intclk_pkg;

    typedef enum logic [1:0] {
        PATH_SLOW   = 2'd0,
        PATH_DIV    = 2'd1,
        PATH_DIRECT = 2'd2
    } path_t;

    localparam int PIN_MODE_W = 2;

    typedef enum logic [PIN_MODE_W-1:0] {
        PM_EXT        = 2'b00,
        PM_INT_CLKOUT = 2'b01,
        PM_INT_GPIO   = 2'b10,
        PM_RSVD       = 2'b11
    } pin_mode_t;

endpackage

// File: rtl/ics_postscaler.sv
module ics_postscaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int SEL_MAX = (2 ** SEL_W) - 1;
    localparam int CNT_W   = SEL_MAX - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:1]   tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // tap k marks the wrap of a divide-by-2^k period
    for (genvar k = 1; k <= CNT_W; k++) begin : g_tap
        assign tap[k] = &cnt[k-1:0];
    end

    always_comb begin
        tick = 1'b0;
        for (int k = 1; k <= CNT_W; k++) begin
            if (sel == SEL_W'(SEL_MAX - k)) begin
                tick = tap[k];
            end
        end
    end

    // R3: after a restart the divide counter begins a fresh period at zero
    p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

endmodule

// File: rtl/ics_path_fsm.sv
module ics_path_fsm
    import intclk_pkg::*;
#(
    parameter int               SEL_W     = 3,
    parameter logic [SEL_W-1:0] RESET_SEL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] freq_sel,
    input  logic             slow_tick,
    input  logic             div_tick,
    output logic [SEL_W-1:0] act_sel,
    output path_t            path,
    output logic             sys_ce,
    output logic             restart
);
    localparam logic [SEL_W-1:0] SEL_SLOW   = '0;
    localparam logic [SEL_W-1:0] SEL_DIRECT = '1;

    function automatic path_t decode(input logic [SEL_W-1:0] s);
        if (s == SEL_SLOW) begin
            return PATH_SLOW;
        end else if (s == SEL_DIRECT) begin
            return PATH_DIRECT;
        end
        return PATH_DIV;
    endfunction

    path_t state;

    // state register: T_APPLY on a pulse, T_STAY otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= decode(RESET_SEL);
            act_sel <= RESET_SEL;
        end else if (sys_ce) begin
            state   <= decode(freq_sel);
            act_sel <= freq_sel;
        end
    end

    // outputs
    always_comb begin
        sys_ce = 1'b0;
        unique case (state)
            PATH_SLOW:   sys_ce = slow_tick;
            PATH_DIV:    sys_ce = div_tick;
            PATH_DIRECT: sys_ce = 1'b1;
            default:     sys_ce = 1'b0;
        endcase
        restart = sys_ce && (freq_sel != act_sel);
        path    = state;
    end

    // R5: the active selection only moves on a period boundary
    p_hold_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_ce |=> $stable(act_sel));

    // R2: the undivided path never skips a cycle
    p_direct_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PATH_DIRECT) |-> sys_ce);

    // R4: the slow path pulses exactly with its tick
    p_slow_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PATH_SLOW) |-> (sys_ce == slow_tick));

endmodule

// File: rtl/ics_clkout.sv
module ics_clkout (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_ce,
    output logic clkout
);
    logic phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= 1'b0;
            clkout <= 1'b0;
        end else if (sys_ce) begin
            phase <= ~phase;
            if (phase) begin
                clkout <= ~clkout;
            end
        end
    end

    // R9: the divided clock only changes after a system enable
    p_clkout_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clkout) |-> $past(sys_ce));

endmodule

// File: rtl/ics_pin_mux.sv
module ics_pin_mux
    import intclk_pkg::*;
(
    input  logic [PIN_MODE_W-1:0] pin_mode,
    input  logic                  clkout,
    output logic                  osc1_gpio,
    output logic                  osc2_gpio,
    output logic                  osc2_clk_en,
    output logic                  osc2_out
);
    always_comb begin
        osc1_gpio   = 1'b0;
        osc2_gpio   = 1'b0;
        osc2_clk_en = 1'b0;
        unique case (pin_mode_t'(pin_mode))
            PM_EXT, PM_RSVD: begin
            end
            PM_INT_CLKOUT: begin
                osc1_gpio   = 1'b1;
                osc2_clk_en = 1'b1;
            end
            PM_INT_GPIO: begin
                osc1_gpio = 1'b1;
                osc2_gpio = 1'b1;
            end
            default: begin
            end
        endcase
        osc2_out = osc2_clk_en & clkout;
    end

    // R8: pin 2 is never GPIO and clock output at once
    always_comb begin
        p_pin_excl_r8: assert (!(osc2_gpio && osc2_clk_en));
    end

endmodule

// File: rtl/intclk_selector.sv
module intclk_selector
    import intclk_pkg::*;
#(
    parameter int               SEL_W     = 3,
    parameter logic [SEL_W-1:0] RESET_SEL = '1
) (
    input  logic                  clk_fast,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      freq_sel,
    input  logic                  slow_tick,
    input  logic                  int_src_sel,
    input  logic                  en_pwrup_tmr,
    input  logic                  en_fail_mon,
    input  logic                  en_wdog,
    input  logic                  en_two_speed,
    input  logic [PIN_MODE_W-1:0] pin_mode,
    output logic                  sys_ce,
    output logic                  fast_osc_en,
    output logic                  slow_osc_en,
    output logic                  osc1_gpio,
    output logic                  osc2_gpio,
    output logic                  osc2_clk_en,
    output logic                  osc2_out
);
    logic [SEL_W-1:0] act_sel;
    path_t            path;
    logic             div_tick;
    logic             restart;
    logic             clkout;

    ics_postscaler #(.SEL_W(SEL_W)) u_post (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .restart (restart),
        .sel     (act_sel),
        .tick    (div_tick)
    );

    ics_path_fsm #(.SEL_W(SEL_W), .RESET_SEL(RESET_SEL)) u_fsm (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .freq_sel  (freq_sel),
        .slow_tick (slow_tick),
        .div_tick  (div_tick),
        .act_sel   (act_sel),
        .path      (path),
        .sys_ce    (sys_ce),
        .restart   (restart)
    );

    ics_clkout u_clkout (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .sys_ce (sys_ce),
        .clkout (clkout)
    );

    ics_pin_mux u_pins (
        .pin_mode    (pin_mode),
        .clkout      (clkout),
        .osc1_gpio   (osc1_gpio),
        .osc2_gpio   (osc2_gpio),
        .osc2_clk_en (osc2_clk_en),
        .osc2_out    (osc2_out)
    );

    assign fast_osc_en = (freq_sel != '0) || (path != PATH_SLOW);
    assign slow_osc_en = int_src_sel | en_pwrup_tmr | en_fail_mon
                       | en_wdog | en_two_speed;

    // R6: an active fast path keeps its oscillator running
    p_fast_hold_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (path != PATH_SLOW) |-> fast_osc_en);

    // R7: the watchdog alone keeps the slow oscillator running
    p_wdog_slow_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        en_wdog |-> slow_osc_en);

endmodule

// File: tb/tb_intclk_selector.sv
module tb_intclk_selector;

    logic       clk_fast = 1'b0;
    logic       rst_n;
    logic [2:0] freq_sel;
    logic       slow_tick;
    logic       int_src_sel, en_pwrup_tmr, en_fail_mon, en_wdog, en_two_speed;
    logic [1:0] pin_mode;
    logic       sys_ce, fast_osc_en, slow_osc_en;
    logic       osc1_gpio, osc2_gpio, osc2_clk_en, osc2_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk_fast = ~clk_fast;

    intclk_selector dut (
        .clk_fast     (clk_fast),
        .rst_n        (rst_n),
        .freq_sel     (freq_sel),
        .slow_tick    (slow_tick),
        .int_src_sel  (int_src_sel),
        .en_pwrup_tmr (en_pwrup_tmr),
        .en_fail_mon  (en_fail_mon),
        .en_wdog      (en_wdog),
        .en_two_speed (en_two_speed),
        .pin_mode     (pin_mode),
        .sys_ce       (sys_ce),
        .fast_osc_en  (fast_osc_en),
        .slow_osc_en  (slow_osc_en),
        .osc1_gpio    (osc1_gpio),
        .osc2_gpio    (osc2_gpio),
        .osc2_clk_en  (osc2_clk_en),
        .osc2_out     (osc2_out)
    );

    // {select, expected period in fast cycles}
    localparam logic [9:0] VEC [7] = '{
        {3'd3, 7'd16}, {3'd1, 7'd64}, {3'd6, 7'd2}, {3'd7, 7'd1},
        {3'd5, 7'd4},  {3'd2, 7'd32}, {3'd4, 7'd8}
    };

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    // move to the drive point of the next cycle
    task automatic next_cycle();
        @(posedge clk_fast);
        #1;
    endtask

    // count cycles up to and including the next sys_ce pulse; ends at its negedge
    task automatic wait_pulse(output int waited);
        waited = 0;
        forever begin
            @(negedge clk_fast);
            waited++;
            if (sys_ce || waited >= 200) break;
            next_cycle();
        end
    endtask

    initial begin
        int w;
        logic hist [32];
        rst_n = 1'b0; freq_sel = 3'd7; slow_tick = 1'b0;
        int_src_sel = 0; en_pwrup_tmr = 0; en_fail_mon = 0; en_wdog = 0; en_two_speed = 0;
        pin_mode = 2'b01;
        repeat (3) @(posedge clk_fast);
        @(negedge clk_fast);
        chk("R1 sys_ce during reset", sys_ce, 1);
        chk("R1 osc2_out during reset", osc2_out, 0);
        @(posedge clk_fast); #1;
        rst_n = 1'b1;

        // R1 / R9: phase of the divided clock after reset
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_fast);
            chk("R1 osc2_out after reset", osc2_out, (i / 2) % 2);
            chk("R2 direct sys_ce", sys_ce, 1);
            next_cycle();
        end

        // R2 / R3 / R5: each selection, boundary then two full periods
        for (int v = 0; v < 7; v++) begin
            freq_sel = VEC[v][9:7];
            wait_pulse(w);
            next_cycle();
            wait_pulse(w);
            chk((VEC[v][9:7] == 3'd7) ? "R5 R2 first period" : "R5 R3 first period",
                w, int'(VEC[v][6:0]));
            next_cycle();
            wait_pulse(w);
            chk((VEC[v][9:7] == 3'd7) ? "R2 steady period" : "R3 steady period",
                w, int'(VEC[v][6:0]));
            next_cycle();
        end

        // R5: change in the middle of a /64 period waits for its end
        freq_sel = 3'd1;
        wait_pulse(w); next_cycle();
        wait_pulse(w); next_cycle();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk_fast);
            chk("R3 no pulse inside /64 period", sys_ce, 0);
            next_cycle();
        end
        freq_sel = 3'd6;
        wait_pulse(w);
        chk("R5 old period completes", w, 59);
        next_cycle();
        wait_pulse(w);
        chk("R5 new /2 period", w, 2);
        next_cycle();

        // R9: /2 path, divided clock holds for 4 cycles per half
        for (int i = 0; i < 24; i++) begin
            @(negedge clk_fast);
            hist[i] = osc2_out;
            if (i >= 4) chk("R9 half period under /2", hist[i], !hist[i-4]);
            next_cycle();
        end

        // R4 / R6: slow path
        freq_sel = 3'd0;
        wait_pulse(w);
        next_cycle();
        for (int i = 0; i < 20; i++) begin
            slow_tick = (i % 7 == 3);
            @(negedge clk_fast);
            chk("R4 sys_ce follows slow_tick", sys_ce, slow_tick);
            chk("R6 fast_osc_en off on slow", fast_osc_en, 0);
            next_cycle();
        end
        slow_tick = 1'b0;

        // R5 / R6: no tick, no change applied
        freq_sel = 3'd7;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_fast);
            chk("R5 change held without tick", sys_ce, 0);
            chk("R6 fast_osc_en on request", fast_osc_en, 1);
            next_cycle();
        end
        slow_tick = 1'b1;
        @(negedge clk_fast);
        chk("R4 tick pulse", sys_ce, 1);
        next_cycle();
        slow_tick = 1'b0;
        @(negedge clk_fast);
        chk("R5 direct after tick", sys_ce, 1);
        next_cycle();

        // R9: direct path, divided clock has period 4 cycles
        for (int i = 0; i < 12; i++) begin
            @(negedge clk_fast);
            hist[i] = osc2_out;
            if (i >= 2) chk("R9 half period direct", hist[i], !hist[i-2]);
            next_cycle();
        end

        // R7: slow oscillator request
        #1 chk("R7 none enabled", slow_osc_en, 0);
        for (int i = 0; i < 5; i++) begin
            {int_src_sel, en_pwrup_tmr, en_fail_mon, en_wdog, en_two_speed} = 5'b10000 >> i;
            #1 chk("R7 single enable", slow_osc_en, 1);
        end
        {int_src_sel, en_pwrup_tmr, en_fail_mon, en_wdog, en_two_speed} = 5'b0;
        #1 chk("R7 cleared", slow_osc_en, 0);

        // R8 / R9: pin modes, sampled while osc2 clock is high or low
        for (int m = 0; m < 4; m++) begin
            logic [2:0] exp_sel;
            pin_mode = 2'(m);
            @(negedge clk_fast);
            case (m)
                1:       exp_sel = 3'b101;
                2:       exp_sel = 3'b110;
                default: exp_sel = 3'b000;
            endcase
            chk("R8 pin selects", {osc1_gpio, osc2_gpio, osc2_clk_en}, exp_sel);
            for (int i = 0; i < 4; i++) begin
                if (m != 1) chk("R9 osc2_out muted", osc2_out, 0);
                next_cycle();
                @(negedge clk_fast);
            end
            next_cycle();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500us;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule